// File: doc/BRIEF.md
# Condition-Prefix Decoder and Predication Unit

This unit sits beside the decode stage of a core that has no architectural flag register in its base mode. It tracks which of two execution modes the core is in. A committed indirect jump sets the mode: the low bit of the jump target selects the extended mode when it is 1 and the compatible mode when it is 0. In the extended mode the core may issue a prefix word that carries three immediates. The prefix is a flag operation, an immediate flag value and a condition code. It retires as a NOP and shapes only the one instruction that issues after it.

When that next instruction issues, the unit drives its controls towards the ALU and commit logic. Flag-set and flag-read strobes go to the ALU. A conditional-set strobe comes with the 4-bit value to load into the flags. A commit strobe goes low when a predicate fails, which suppresses the register write and any jump. The predicate is checked against the 4-bit flag register that is presented on `flags_i` in the order {N, Z, C, V} (bit 3 to bit 0). The flag register itself, fetch and the arithmetic are not part of this block.

Top module: `cond_prefix_unit`

## Requirements
- R1: During and after reset the unit is in the compatible mode (`ext_mode_o` = 0), no prefix is pending, and an issuing instruction commits with all flag controls low.
- R2: When `ijmp_valid_i` is sampled at a clock edge, `ext_mode_o` takes bit 0 of `ijmp_target_i` from that edge onward. Without a jump the mode holds.
- R3: In the compatible mode a prefix has no effect. `illegal_o` stays low, nothing becomes pending, and the next instruction commits with all flag controls low.
- R4: The prefix word holds the operation in bits 2:0, the immediate flags in bits 6:3 and the condition code in bits 10:7. Operation 001 raises `flag_set_o`, 010 raises `flag_ref_o` and 011 raises both on the next issuing instruction, and that instruction commits.
- R5: With operation 110, the next instruction raises `flag_set_o` when the condition holds on `flags_i`. When the condition does not hold it raises `flag_cset_o` and drives the prefix's immediate flags on `cset_val_o`. It commits in both cases.
- R6: With operation 000, the next instruction commits only when the condition code holds. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), and 14 and 15 always.
- R7: A pending prefix affects exactly one issuing instruction and is then cleared. A second prefix before any issue replaces the first one.
- R8: A prefix with a reserved operation (100, 101, 111) in the extended mode raises `illegal_o` in that same cycle and leaves nothing pending.
- R9: In a cycle that presents a prefix, `issue_valid_i` is ignored: `commit_o` and all flag controls stay low.
- R10: A committed indirect jump discards any pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ijmp_valid_i | input | 1 | A committed indirect jump takes effect |
| ijmp_target_i | input | ADDR_W | Target address of that jump |
| prefix_valid_i | input | 1 | The decode slot holds a prefix word |
| prefix_imm_i | input | 11 | Prefix immediates {cc, imm flags, op} |
| issue_valid_i | input | 1 | A non-prefix instruction issues |
| flags_i | input | 4 | Current flags {N, Z, C, V} |
| ext_mode_o | output | 1 | 1 = extended mode |
| commit_o | output | 1 | Issuing instruction commits |
| flag_set_o | output | 1 | ALU writes flags from its result |
| flag_ref_o | output | 1 | ALU reads flags as an operand |
| flag_cset_o | output | 1 | Flags load `cset_val_o` |
| cset_val_o | output | 4 | Value for the conditional flag load |
| illegal_o | output | 1 | Reserved prefix operation |

## Verification
The bench builds the unit with its defaults: a 32-bit target address, with the mode taken from bit 0. This allows targets with only high bits set, with all bits set, and with bit 0 alone set, so any mode selection that looks at the wrong bit is caught. Every condition code is checked against all sixteen flag combinations. The single-use rule is checked by issuing back-to-back instructions, by sending two prefixes in a row, and by placing a jump between a prefix and its consumer.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int OP_W   = 3;
  localparam int FLAG_W = 4;
  localparam int CC_W   = 4;
  localparam int IMM_W  = OP_W + FLAG_W + CC_W;
  localparam int OP_LSB = 0;
  localparam int FI_LSB = OP_LSB + OP_W;
  localparam int CC_LSB = FI_LSB + FLAG_W;

  localparam logic [OP_W-1:0] OP_NONE   = 3'b000;
  localparam logic [OP_W-1:0] OP_SET    = 3'b001;
  localparam logic [OP_W-1:0] OP_REF    = 3'b010;
  localparam logic [OP_W-1:0] OP_SETREF = 3'b011;
  localparam logic [OP_W-1:0] OP_CSET   = 3'b110;

  localparam logic [CC_W-1:0] CC_ALWAYS = 4'he;

  // flag bit positions in flags vectors
  localparam int F_N = 3;
  localparam int F_Z = 2;
  localparam int F_C = 1;
  localparam int F_V = 0;

  typedef struct packed {
    logic              valid;
    logic [OP_W-1:0]   op;
    logic [FLAG_W-1:0] fimm;
    logic [CC_W-1:0]   cc;
  } pend_t;

  function automatic logic op_reserved(input logic [OP_W-1:0] op);
    case (op)
      OP_NONE, OP_SET, OP_REF, OP_SETREF, OP_CSET: op_reserved = 1'b0;
      default:                                     op_reserved = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cpx_mode_track.sv
module cpx_mode_track #(
  parameter int ADDR_W   = 32,
  parameter int MODE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ijmp_valid_i,
  input  logic [ADDR_W-1:0] ijmp_target_i,
  output logic              ext_mode_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mode_q <= 1'b0;
    else if (ijmp_valid_i) mode_q <= ijmp_target_i[MODE_BIT];
  end

  assign ext_mode_o = mode_q;
endmodule

// File: rtl/cpx_prefix_dec.sv
module cpx_prefix_dec
  import cpx_pkg::*;
(
  input  logic             prefix_valid_i,
  input  logic             ext_mode_i,
  input  logic [IMM_W-1:0] prefix_imm_i,
  output logic             seen_o,
  output logic             load_o,
  output logic             illegal_o,
  output pend_t            fields_o
);
  logic [OP_W-1:0] op;

  assign op       = prefix_imm_i[OP_LSB +: OP_W];
  assign seen_o   = prefix_valid_i & ext_mode_i;
  assign illegal_o = seen_o & op_reserved(op);
  assign load_o   = seen_o & ~op_reserved(op);

  always_comb begin
    fields_o       = '0;
    fields_o.valid = 1'b1;
    fields_o.op    = op;
    fields_o.fimm  = prefix_imm_i[FI_LSB +: FLAG_W];
    fields_o.cc    = prefix_imm_i[CC_LSB +: CC_W];
  end
endmodule

// File: rtl/cpx_pend_reg.sv
module cpx_pend_reg
  import cpx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  seen_i,
  input  logic  load_i,
  input  pend_t fields_i,
  input  logic  consume_i,
  output pend_t pend_o
);
  pend_t pend_q;

  // jump flush wins, then a new prefix (legal loads, reserved empties), then use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= '0;
    else if (flush_i)   pend_q <= '0;
    else if (seen_i)    pend_q <= load_i ? fields_i : '0;
    else if (consume_i) pend_q <= '0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cpx_issue_ctl.sv
module cpx_issue_ctl
  import cpx_pkg::*;
(
  input  logic              fire_i,
  input  logic              ext_mode_i,
  input  pend_t             pend_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              commit_o,
  output logic              flag_set_o,
  output logic              flag_ref_o,
  output logic              flag_cset_o,
  output logic [FLAG_W-1:0] cset_val_o
);
  logic n, z, c, v, pass;

  assign n = flags_i[F_N];
  assign z = flags_i[F_Z];
  assign c = flags_i[F_C];
  assign v = flags_i[F_V];

  always_comb begin
    case (pend_i.cc)
      4'd0:    pass = z;
      4'd1:    pass = ~z;
      4'd2:    pass = c;
      4'd3:    pass = ~c;
      4'd4:    pass = n;
      4'd5:    pass = ~n;
      4'd6:    pass = v;
      4'd7:    pass = ~v;
      4'd8:    pass = c & ~z;
      4'd9:    pass = ~c | z;
      4'd10:   pass = (n == v);
      4'd11:   pass = (n != v);
      4'd12:   pass = ~z & (n == v);
      4'd13:   pass = z | (n != v);
      default: pass = 1'b1;
    endcase
  end

  always_comb begin
    commit_o    = fire_i;
    flag_set_o  = 1'b0;
    flag_ref_o  = 1'b0;
    flag_cset_o = 1'b0;
    cset_val_o  = '0;
    if (fire_i && ext_mode_i && pend_i.valid) begin
      case (pend_i.op)
        OP_NONE:   commit_o = pass;
        OP_SET:    flag_set_o = 1'b1;
        OP_REF:    flag_ref_o = 1'b1;
        OP_SETREF: begin
          flag_set_o = 1'b1;
          flag_ref_o = 1'b1;
        end
        OP_CSET: begin
          flag_set_o  = pass;
          flag_cset_o = ~pass;
          cset_val_o  = pass ? '0 : pend_i.fimm;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cond_prefix_unit.sv
module cond_prefix_unit
  import cpx_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MODE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ijmp_valid_i,
  input  logic [ADDR_W-1:0] ijmp_target_i,
  input  logic              prefix_valid_i,
  input  logic [IMM_W-1:0]  prefix_imm_i,
  input  logic              issue_valid_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              ext_mode_o,
  output logic              commit_o,
  output logic              flag_set_o,
  output logic              flag_ref_o,
  output logic              flag_cset_o,
  output logic [FLAG_W-1:0] cset_val_o,
  output logic              illegal_o
);
  logic  ext_mode, seen, load, fire;
  pend_t fields, pend;

  assign fire = issue_valid_i & ~prefix_valid_i;

  cpx_mode_track #(.ADDR_W(ADDR_W), .MODE_BIT(MODE_BIT)) u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ijmp_valid_i  (ijmp_valid_i),
    .ijmp_target_i (ijmp_target_i),
    .ext_mode_o    (ext_mode)
  );

  cpx_prefix_dec u_dec (
    .prefix_valid_i (prefix_valid_i),
    .ext_mode_i     (ext_mode),
    .prefix_imm_i   (prefix_imm_i),
    .seen_o         (seen),
    .load_o         (load),
    .illegal_o      (illegal_o),
    .fields_o       (fields)
  );

  cpx_pend_reg u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (ijmp_valid_i),
    .seen_i    (seen),
    .load_i    (load),
    .fields_i  (fields),
    .consume_i (fire),
    .pend_o    (pend)
  );

  cpx_issue_ctl u_ctl (
    .fire_i      (fire),
    .ext_mode_i  (ext_mode),
    .pend_i      (pend),
    .flags_i     (flags_i),
    .commit_o    (commit_o),
    .flag_set_o  (flag_set_o),
    .flag_ref_o  (flag_ref_o),
    .flag_cset_o (flag_cset_o),
    .cset_val_o  (cset_val_o)
  );

  assign ext_mode_o = ext_mode;
endmodule

// File: rtl/cond_prefix_unit_chk.sv
module cond_prefix_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int MODE_BIT = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ijmp_valid_i,
  input logic [ADDR_W-1:0] ijmp_target_i,
  input logic              prefix_valid_i,
  input logic              issue_valid_i,
  input logic              ext_mode_o,
  input logic              commit_o,
  input logic              flag_set_o,
  input logic              flag_ref_o,
  input logic              flag_cset_o,
  input logic              illegal_o
);
  logic any_flag;
  assign any_flag = flag_set_o | flag_ref_o | flag_cset_o;

  assert_reset_mode_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !ext_mode_o);

  assert_mode_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ijmp_valid_i |=> ext_mode_o == $past(ijmp_target_i[MODE_BIT]));

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ijmp_valid_i |=> $stable(ext_mode_o));

  assert_compat_plain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode_o && issue_valid_i && !prefix_valid_i) |-> commit_o && !any_flag);

  assert_single_use_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !prefix_valid_i) |=> !any_flag);

  assert_illegal_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ext_mode_o && prefix_valid_i);

  assert_illegal_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !any_flag);

  assert_prefix_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_valid_i |-> !commit_o && !any_flag);

  assert_jump_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ijmp_valid_i |=> !any_flag);
endmodule

bind cond_prefix_unit cond_prefix_unit_chk #(.ADDR_W(ADDR_W), .MODE_BIT(MODE_BIT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ijmp_valid_i   (ijmp_valid_i),
  .ijmp_target_i  (ijmp_target_i),
  .prefix_valid_i (prefix_valid_i),
  .issue_valid_i  (issue_valid_i),
  .ext_mode_o     (ext_mode_o),
  .commit_o       (commit_o),
  .flag_set_o     (flag_set_o),
  .flag_ref_o     (flag_ref_o),
  .flag_cset_o    (flag_cset_o),
  .illegal_o      (illegal_o)
);

// File: tb/tb_cond_prefix_unit.sv
module tb_cond_prefix_unit;
  localparam int ADDR_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ijmp_valid_i = 1'b0;
  logic [ADDR_W-1:0] ijmp_target_i = '0;
  logic              prefix_valid_i = 1'b0;
  logic [10:0]       prefix_imm_i = '0;
  logic              issue_valid_i = 1'b0;
  logic [3:0]        flags_i = '0;
  logic              ext_mode_o, commit_o, flag_set_o, flag_ref_o, flag_cset_o, illegal_o;
  logic [3:0]        cset_val_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // sampled outputs
  logic s_commit, s_set, s_ref, s_cset, s_ill;
  logic [3:0] s_val;

  cond_prefix_unit #(.ADDR_W(ADDR_W), .MODE_BIT(0)) dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit cond_ref(input int cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c && !z;  9: return !c || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // all tasks start and end at a falling edge
  task automatic pfx(input logic [2:0] op, input logic [3:0] fi, input logic [3:0] cc);
    prefix_valid_i = 1'b1;
    prefix_imm_i   = {cc, fi, op};
    #1;
    s_ill = illegal_o;
    @(negedge clk_i);
    prefix_valid_i = 1'b0;
  endtask

  task automatic iss(input logic [3:0] f);
    issue_valid_i = 1'b1;
    flags_i       = f;
    #1;
    s_commit = commit_o; s_set = flag_set_o; s_ref = flag_ref_o;
    s_cset = flag_cset_o; s_val = cset_val_o;
    @(negedge clk_i);
    issue_valid_i = 1'b0;
  endtask

  task automatic jmp(input logic [ADDR_W-1:0] t);
    ijmp_valid_i  = 1'b1;
    ijmp_target_i = t;
    @(negedge clk_i);
    ijmp_valid_i  = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 mode in reset", ext_mode_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 mode after reset", ext_mode_o, 0);
    iss(4'h0);
    chk("R1 commit", s_commit, 1);
    chk("R1 no flag ctl", {s_set, s_ref, s_cset}, 0);
  endtask

  task automatic t_mode;
    jmp(32'h0000_1001);
    chk("R2 odd target ext", ext_mode_o, 1);
    jmp(32'h8000_0000);
    chk("R2 high-only target compat", ext_mode_o, 0);
    jmp(32'hFFFF_FFFF);
    chk("R2 all-ones ext", ext_mode_o, 1);
    jmp(32'hFFFF_FFFE);
    chk("R2 even target compat", ext_mode_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R2 mode holds", ext_mode_o, 0);
  endtask

  task automatic t_compat;
    pfx(3'b001, 4'h0, 4'he);
    chk("R3 no illegal", s_ill, 0);
    iss(4'h0);
    chk("R3 commit", s_commit, 1);
    chk("R3 no set", s_set, 0);
    pfx(3'b111, 4'h0, 4'h0);
    chk("R3 reserved ignored", s_ill, 0);
    pfx(3'b000, 4'h0, 4'h0);
    iss(4'h0);
    chk("R3 no predication", s_commit, 1);
  endtask

  task automatic t_ops;
    jmp(32'h1);
    pfx(3'b001, 4'h0, 4'he); iss(4'h0);
    chk("R4 op001 set/ref", {s_set, s_ref, s_commit}, 3'b101);
    pfx(3'b010, 4'h0, 4'he); iss(4'h0);
    chk("R4 op010 set/ref", {s_set, s_ref, s_commit}, 3'b011);
    pfx(3'b011, 4'h0, 4'he); iss(4'h0);
    chk("R4 op011 set/ref", {s_set, s_ref, s_commit}, 3'b111);
    pfx(3'b000, 4'h0, 4'hf); iss(4'h0);
    chk("R4 op000 always", {s_set, s_ref, s_cset, s_commit}, 4'b0001);
  endtask

  task automatic t_cond;
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        pfx(3'b000, 4'h0, 4'(cc));
        iss(4'(f));
        chk($sformatf("R6 cc=%0d flags=%0h", cc, f), s_commit, int'(cond_ref(cc, 4'(f))));
      end
    end
  endtask

  task automatic t_cset;
    pfx(3'b110, 4'hA, 4'd0); iss(4'b0100);
    chk("R5 pass sets", {s_set, s_cset, s_commit}, 3'b101);
    pfx(3'b110, 4'hA, 4'd0); iss(4'b0000);
    chk("R5 fail cset", {s_set, s_cset, s_commit}, 3'b011);
    chk("R5 cset value", s_val, 4'hA);
    pfx(3'b110, 4'h5, 4'd10); iss(4'b1000);
    chk("R5 GE fail cset value", {s_cset, s_val}, 5'h15);
  endtask

  task automatic t_single;
    pfx(3'b001, 4'h0, 4'he); iss(4'h0); iss(4'h0);
    chk("R7 used once", {s_set, s_commit}, 2'b01);
    pfx(3'b001, 4'h0, 4'he); pfx(3'b010, 4'h0, 4'he); iss(4'h0);
    chk("R7 replace", {s_set, s_ref}, 2'b01);
    pfx(3'b000, 4'h0, 4'd0); iss(4'h0); iss(4'h0);
    chk("R7 predicate once", s_commit, 1);
  endtask

  task automatic t_illegal;
    pfx(3'b100, 4'h0, 4'he); chk("R8 op100", s_ill, 1);
    pfx(3'b101, 4'h0, 4'he); chk("R8 op101", s_ill, 1);
    pfx(3'b111, 4'h0, 4'he); chk("R8 op111", s_ill, 1);
    pfx(3'b001, 4'h0, 4'he); chk("R8 legal low", s_ill, 0);
    pfx(3'b111, 4'h0, 4'he); iss(4'h0);
    chk("R8 pending empty", {s_set, s_ref, s_cset, s_commit}, 4'b0001);
  endtask

  task automatic t_slot;
    pfx(3'b001, 4'h0, 4'he);
    prefix_valid_i = 1'b1; prefix_imm_i = {4'he, 4'h0, 3'b010};
    issue_valid_i  = 1'b1;
    #1;
    chk("R9 no commit", commit_o, 0);
    chk("R9 no flag ctl", {flag_set_o, flag_ref_o, flag_cset_o}, 0);
    @(negedge clk_i);
    prefix_valid_i = 1'b0; issue_valid_i = 1'b0;
    iss(4'h0);
    chk("R9 later prefix pending", {s_set, s_ref}, 2'b01);
  endtask

  task automatic t_flush;
    pfx(3'b001, 4'h0, 4'he);
    jmp(32'h3);
    iss(4'h0);
    chk("R10 flushed", {s_set, s_commit}, 2'b01);
    pfx(3'b000, 4'h0, 4'd0);
    jmp(32'h5);
    iss(4'h0);
    chk("R10 predicate flushed", s_commit, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_mode();
    t_compat();
    t_ops();
    t_cond();
    t_cset();
    t_single();
    t_illegal();
    t_slot();
    t_flush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule